// File: doc/BRIEF.md
# Output Overload Hiccup Protection Controller

This block guards a supply output against overloads and overheating. A digital overload-detect input is resynchronised to the local clock and fed to a small state machine. In dynamic mode an overload turns the output off for a long rest interval. The output then comes back for a short probe interval with the reduced current limit selected. Probing repeats until one probe interval completes with no overload at all. In static mode the output is never switched off by the controller, and the overload flag simply mirrors the synchronised overload signal.

A die-temperature code is compared against a high and a low threshold with hysteresis. While the die is hot, the output is off, the overload cycle is abandoned and the overload flag is held low. The overload flag is also held low until the supply's soft-start has finished. Rest and probe lengths are parameters counted in clock cycles. The defaults give 900 ms plus 20 ms at a 50 MHz clock.

Top module: `hiccup_guard`

## Requirements
- R1: With mode bit `staticMode` low and `softDone` high, an overload asserted on `ovlIn` turns `outEn` low and `ovlFlag` high on the same clock edge, the third rising edge after the input changes (two synchroniser stages plus the state register).
- R2: The rest interval keeps `outEn` low for exactly OFF_CYC cycles. It is followed by a probe interval of exactly ON_CYC cycles in which `outEn` is high and `curLimSel` is high; `ovlFlag` stays high through both.
- R3: If the synchronised overload is high in any cycle of a probe interval, including its last cycle, a new rest interval starts at the end of that probe interval.
- R4: At the end of a probe interval with no synchronised overload, the controller returns to normal operation: `outEn` high, `curLimSel` low and `ovlFlag` low on the same edge.
- R5: With `staticMode` high, `outEn` never falls because of an overload, `curLimSel` stays low, and `ovlFlag` equals `ovlIn` delayed by three clock edges.
- R6: While `softDone` is low, `ovlFlag` is low and no rest interval starts; `outEn` stays high.
- R7: `tempCode` is an unsigned code in degrees Celsius. `otFlag` is set one edge after the code exceeds TEMP_HI (default 150). It is cleared one edge after the code is at or below TEMP_LO (default 130). Between the two it holds its value.
- R8: While `otFlag` is high, `outEn` is low and any overload cycle is abandoned; one edge later `ovlFlag` and `curLimSel` are low. When `otFlag` clears, the output is enabled, and an overload still present starts a rest interval on the following edge.
- R9: Switching `staticMode` from high to low while an overload is present starts a rest interval on the next edge. Switching it from low to high during a rest interval re-enables the output on the next edge.
- R10: A synchronous reset on `rst` leaves `outEn` high and `curLimSel`, `ovlFlag` and `otFlag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovlIn | input | 1 | Overload detect, asynchronous |
| staticMode | input | 1 | 1 = static clamp, 0 = dynamic rest/probe cycling |
| softDone | input | 1 | Soft-start finished |
| tempCode | input | TEMP_W | Die temperature in degrees Celsius, unsigned |
| outEn | output | 1 | Output enable |
| curLimSel | output | 1 | 1 = reduced current limit selected |
| ovlFlag | output | 1 | Overload flag |
| otFlag | output | 1 | Overtemperature flag |

## Verification
The dynamic cycle is exercised with an overload held for one, two and three full rest/probe periods before release. Every cycle is compared against a phase computed from the interval lengths. This separates off-by-one errors in the rest interval from those in the probe interval. A single-cycle glitch placed inside an otherwise clean probe window checks that any overload during the window forces another rest. Plain end-of-window sampling would miss that glitch. Static mode, soft-start masking, runtime mode changes in both directions, a rising and falling temperature sweep across both thresholds, and an overtemperature event that lands in the middle of a rest interval cover the remaining paths.

// File: rtl/hg_pkg.sv
package hg_pkg;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_OFF = 2'd1,
    ST_ON  = 2'd2
  } hgState_e;

  typedef struct packed {
    logic loadOff;
    logic loadOn;
  } hgStrobe_t;

endpackage

// File: rtl/hg_datapath.sv
module hg_datapath
  import hg_pkg::*;
#(
  parameter int OFF_CYC = 45_000_000,
  parameter int ON_CYC  = 1_000_000,
  parameter int TEMP_W  = 8,
  parameter int TEMP_HI = 150,
  parameter int TEMP_LO = 130
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovlIn,
  input  logic [TEMP_W-1:0] tempCode,
  input  hgStrobe_t         strb,
  output logic              ovlSync,
  output logic              otFlag,
  output logic              timerDone
);

  localparam int LD_MAX = (OFF_CYC > ON_CYC) ? OFF_CYC : ON_CYC;
  localparam int CNT_W  = $clog2(LD_MAX + 1);
  localparam logic [CNT_W-1:0] OFF_LD = CNT_W'(OFF_CYC - 1);
  localparam logic [CNT_W-1:0] ON_LD  = CNT_W'(ON_CYC - 1);
  localparam logic [TEMP_W-1:0] HI_CODE = TEMP_W'(TEMP_HI);
  localparam logic [TEMP_W-1:0] LO_CODE = TEMP_W'(TEMP_LO);

  logic       syncA;
  logic [CNT_W-1:0] timerCnt;

  // two-stage synchroniser for the asynchronous overload input
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA   <= 1'b0;
      ovlSync <= 1'b0;
    end else begin
      syncA   <= ovlIn;
      ovlSync <= syncA;
    end
  end

  // temperature comparator with hysteresis
  always_ff @(posedge clk) begin
    if (rst) begin
      otFlag <= 1'b0;
    end else if (tempCode > HI_CODE) begin
      otFlag <= 1'b1;
    end else if (tempCode <= LO_CODE) begin
      otFlag <= 1'b0;
    end
  end

  // shared down-counter for rest and probe intervals
  always_ff @(posedge clk) begin
    if (rst) begin
      timerCnt <= '0;
    end else if (strb.loadOff) begin
      timerCnt <= OFF_LD;
    end else if (strb.loadOn) begin
      timerCnt <= ON_LD;
    end else if (timerCnt != '0) begin
      timerCnt <= timerCnt - 1'b1;
    end
  end

  assign timerDone = (timerCnt == '0);

  AST_OT_SET: assert property (@(posedge clk) disable iff (rst)
    (tempCode > HI_CODE) |=> otFlag);                                 // R7
  AST_OT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (otFlag && tempCode > LO_CODE) |=> otFlag);                       // R7
  AST_OT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (tempCode <= LO_CODE) |=> !otFlag);                               // R7
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    (timerCnt <= CNT_W'(LD_MAX - 1)));                                // R2

endmodule

// File: rtl/hg_ctrl.sv
module hg_ctrl
  import hg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ovlSync,
  input  logic      otFlag,
  input  logic      timerDone,
  input  logic      staticMode,
  input  logic      softDone,
  output hgStrobe_t strb,
  output logic      outEn,
  output logic      curLimSel,
  output logic      ovlFlag
);

  hgState_e stateQ, stateD;
  logic     flagD;
  logic     seenQ, seenD;
  logic     ctrlActive;

  assign ctrlActive = softDone && !staticMode && !otFlag;

  always_comb begin
    stateD = stateQ;
    flagD  = ovlFlag;
    seenD  = seenQ;
    strb   = '0;
    if (otFlag || !softDone) begin
      stateD = ST_RUN;
      flagD  = 1'b0;
      seenD  = 1'b0;
    end else if (staticMode) begin
      stateD = ST_RUN;
      flagD  = ovlSync;
      seenD  = 1'b0;
    end else begin
      case (stateQ)
        ST_RUN: begin
          flagD = ovlSync;
          if (ovlSync) begin
            stateD       = ST_OFF;
            strb.loadOff = 1'b1;
          end
        end
        ST_OFF: begin
          flagD = 1'b1;
          if (timerDone) begin
            stateD      = ST_ON;
            strb.loadOn = 1'b1;
            seenD       = 1'b0;
          end
        end
        ST_ON: begin
          flagD = 1'b1;
          if (timerDone) begin
            if (seenQ || ovlSync) begin
              stateD       = ST_OFF;
              strb.loadOff = 1'b1;
            end else begin
              stateD = ST_RUN;
              flagD  = 1'b0;
            end
            seenD = 1'b0;
          end else if (ovlSync) begin
            seenD = 1'b1;
          end
        end
        default: begin
          stateD = ST_RUN;
          flagD  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_RUN;
      ovlFlag <= 1'b0;
      seenQ   <= 1'b0;
    end else begin
      stateQ  <= stateD;
      ovlFlag <= flagD;
      seenQ   <= seenD;
    end
  end

  assign outEn     = !otFlag && (stateQ != ST_OFF);
  assign curLimSel = !otFlag && (stateQ == ST_ON);

  AST_OFF_FLAG: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_OFF) |-> ovlFlag);                                  // R1
  AST_ON_FROM_OFF: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ON) |-> ($past(stateQ) != ST_RUN));                  // R2
  AST_CLEAN_END: assert property (@(posedge clk) disable iff (rst)
    (ctrlActive && stateQ == ST_ON && timerDone && !seenQ && !ovlSync)
      |=> (stateQ == ST_RUN && !ovlFlag));                            // R4
  AST_STATIC_RUN: assert property (@(posedge clk) disable iff (rst)
    (staticMode && softDone) |=> (stateQ != ST_OFF));                 // R5
  AST_SOFT_LOW: assert property (@(posedge clk) disable iff (rst)
    !softDone |=> !ovlFlag);                                          // R6
  AST_OT_IDLE: assert property (@(posedge clk) disable iff (rst)
    otFlag |=> (stateQ == ST_RUN && !ovlFlag));                       // R8

endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hg_pkg::*;
#(
  parameter int OFF_CYC = 45_000_000,
  parameter int ON_CYC  = 1_000_000,
  parameter int TEMP_W  = 8,
  parameter int TEMP_HI = 150,
  parameter int TEMP_LO = 130
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovlIn,
  input  logic              staticMode,
  input  logic              softDone,
  input  logic [TEMP_W-1:0] tempCode,
  output logic              outEn,
  output logic              curLimSel,
  output logic              ovlFlag,
  output logic              otFlag
);

  hgStrobe_t strb;
  logic      ovlSync;
  logic      timerDone;

  hg_datapath #(
    .OFF_CYC(OFF_CYC),
    .ON_CYC (ON_CYC),
    .TEMP_W (TEMP_W),
    .TEMP_HI(TEMP_HI),
    .TEMP_LO(TEMP_LO)
  ) uDp (
    .clk      (clk),
    .rst      (rst),
    .ovlIn    (ovlIn),
    .tempCode (tempCode),
    .strb     (strb),
    .ovlSync  (ovlSync),
    .otFlag   (otFlag),
    .timerDone(timerDone)
  );

  hg_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .ovlSync   (ovlSync),
    .otFlag    (otFlag),
    .timerDone (timerDone),
    .staticMode(staticMode),
    .softDone  (softDone),
    .strb      (strb),
    .outEn     (outEn),
    .curLimSel (curLimSel),
    .ovlFlag   (ovlFlag)
  );

endmodule

// File: tb/tb_hiccup_guard.sv
module tb_hiccup_guard;

  localparam int OFF = 12;
  localparam int ON  = 5;
  localparam int P   = OFF + ON;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ovlIn = 1'b0;
  logic       staticMode = 1'b0;
  logic       softDone = 1'b0;
  logic [7:0] tempCode = 8'd40;
  logic       outEn, curLimSel, ovlFlag, otFlag;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hiccup_guard #(.OFF_CYC(OFF), .ON_CYC(ON)) dut (
    .clk(clk), .rst(rst), .ovlIn(ovlIn), .staticMode(staticMode),
    .softDone(softDone), .tempCode(tempCode), .outEn(outEn),
    .curLimSel(curLimSel), .ovlFlag(ovlFlag), .otFlag(otFlag)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
    end
  endtask

  task automatic chkAll(string req, logic eEn, logic eLim, logic eFlag);
    chk(req, "outEn", outEn, eEn);
    chk(req, "curLimSel", curLimSel, eLim);
    chk(req, "ovlFlag", ovlFlag, eFlag);
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  // R1 R2 R3 R4: overload held for k periods, released early in the k-th rest
  task automatic hiccupRun(int k);
    int nRel;
    nRel = 3 + (k - 1) * P + 2;
    ovlIn = 1'b1;
    for (int n = 1; n <= 3 + k * P + 4; n++) begin
      int m;
      step();
      m = n - 3;
      if (n < 3) chkAll("R1", 1'b1, 1'b0, 1'b0);
      else if (m >= k * P) chkAll("R4", 1'b1, 1'b0, 1'b0);
      else if ((m % P) < OFF) chkAll("R2", 1'b0, 1'b0, 1'b1);
      else chkAll("R3", 1'b1, 1'b1, 1'b1);
      if (n == nRel) ovlIn = 1'b0;
    end
    idle(4);
  endtask

  initial begin
    string tag;
    logic expOt;
    idle(3);
    rst = 1'b0;
    step();
    chkAll("R10", 1'b1, 1'b0, 1'b0);
    chk("R10", "otFlag", otFlag, 1'b0);

    // R6: soft-start not done, overload masked
    ovlIn = 1'b1;
    for (int n = 0; n < 20; n++) begin
      step();
      chkAll("R6", 1'b1, 1'b0, 1'b0);
    end
    ovlIn = 1'b0;
    idle(4);
    softDone = 1'b1;
    idle(2);

    for (int k = 1; k <= 3; k++) hiccupRun(k);

    // R3: single-cycle glitch inside a probe window forces another rest
    ovlIn = 1'b1;
    for (int n = 1; n <= 3 + P + P + 3; n++) begin
      step();
      if (n == 5) ovlIn = 1'b0;
      if (n == 3 + OFF + 1) ovlIn = 1'b1;
      else if (n == 3 + OFF + 2) ovlIn = 1'b0;
      if (n == 3 + P) chkAll("R3", 1'b0, 1'b0, 1'b1);
      if (n == 3 + P + OFF) chkAll("R2", 1'b1, 1'b1, 1'b1);
      if (n == 3 + P + P) chkAll("R4", 1'b1, 1'b0, 1'b0);
    end
    idle(4);

    // R5: static mode, flag follows input with three-edge delay
    staticMode = 1'b1;
    idle(2);
    ovlIn = 1'b1;
    for (int n = 1; n <= 25; n++) begin
      step();
      chkAll("R5", 1'b1, 1'b0, (n >= 3));
    end
    ovlIn = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      step();
      chkAll("R5", 1'b1, 1'b0, (n < 3));
    end

    // R9: static -> dynamic with overload present, then back during rest
    ovlIn = 1'b1;
    idle(4);
    chkAll("R9", 1'b1, 1'b0, 1'b1);
    staticMode = 1'b0;
    step();
    chkAll("R9", 1'b0, 1'b0, 1'b1);
    idle(3);
    staticMode = 1'b1;
    step();
    chkAll("R9", 1'b1, 1'b0, 1'b1);
    ovlIn = 1'b0;
    idle(4);
    chkAll("R9", 1'b1, 1'b0, 1'b0);
    staticMode = 1'b0;
    idle(2);

    // R7: temperature sweep up and down across both thresholds
    expOt = 1'b0;
    for (int t = 120; t <= 160; t++) begin
      tempCode = 8'(t);
      step();
      if (t > 150) expOt = 1'b1;
      else if (t <= 130) expOt = 1'b0;
      tag = (t > 150) ? "R7" : "R7";
      chk(tag, "otFlag", otFlag, expOt);
      chk("R8", "outEn", outEn, !expOt);
    end
    for (int t = 160; t >= 120; t--) begin
      tempCode = 8'(t);
      step();
      if (t > 150) expOt = 1'b1;
      else if (t <= 130) expOt = 1'b0;
      chk("R7", "otFlag", otFlag, expOt);
      chk("R8", "outEn", outEn, !expOt);
    end
    tempCode = 8'd40;
    idle(3);

    // R8: overtemperature in the middle of a rest interval
    ovlIn = 1'b1;
    idle(6);
    chkAll("R1", 1'b0, 1'b0, 1'b1);
    tempCode = 8'd160;
    step();
    chk("R8", "otFlag", otFlag, 1'b1);
    chk("R8", "outEn", outEn, 1'b0);
    step();
    chkAll("R8", 1'b0, 1'b0, 1'b0);
    idle(OFF + 4);
    chkAll("R8", 1'b0, 1'b0, 1'b0);
    tempCode = 8'd100;
    step();
    chk("R8", "otFlag", otFlag, 1'b0);
    chkAll("R8", 1'b1, 1'b0, 1'b0);
    step();
    chkAll("R8", 1'b0, 1'b0, 1'b1);
    ovlIn = 1'b0;
    idle(P + 4);
    chkAll("R4", 1'b1, 1'b0, 1'b0);

    // R10: reset in the middle of a rest interval
    ovlIn = 1'b1;
    idle(5);
    rst = 1'b1;
    ovlIn = 1'b0;
    step();
    chkAll("R10", 1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    idle(3);
    chkAll("R10", 1'b1, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++;
      nBad++;
      $display("FAIL watchdog all-requirements: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

endmodule